// File: doc/BRIEF.md
# Reservation Monitor for Load-Linked / Store-Conditional

This block sits between a core's memory request port and its memory path and turns a load-linked followed by a store-conditional into an atomic read-modify-write. A load-linked reads memory and records a reservation on its address. A later store-conditional to that address writes memory only if the reservation has survived. Snooped remote invalidate or update traffic to the address, or losing the bus, makes it fail. A failing store-conditional never reaches memory and returns 0. A passing one writes and returns 1.

The block holds a parameterised number of reservations at once, one per distinct address. When every slot is taken, a load-linked to a new address evicts the least recently reserved one. Memory itself is outside the block. The read data for the presented address arrives combinationally on `mem_rdata_i`, and writes leave on a registered write port one cycle after the request. Responses appear on `rsp_valid_o`/`rsp_data_o` one cycle after the request.

Top module: `llsc_monitor`

## Requirements
- R1: After reset, `rsp_valid_o` and `mem_we_o` are 0 and no address is reserved, so a store-conditional issued first fails.
- R2: Request op codes on `req_op_i` are 2'b00 idle, 2'b01 load-linked, 2'b10 store-conditional and 2'b11 ordinary store. A load-linked raises `rsp_valid_o` in the next cycle, with `rsp_data_o` equal to the `mem_rdata_i` seen in the request cycle, and reserves its address.
- R3: A store-conditional to a reserved address, with no bus loss and no matching snoop, returns `rsp_data_o` = 1 in the next cycle. In that same cycle it asserts `mem_we_o` with the request's address and data.
- R4: A store-conditional to an unreserved address returns `rsp_data_o` = 0 and does not assert `mem_we_o`.
- R5: A snoop (`snp_valid_i`) whose address matches a reservation clears it. A snoop to a different address leaves it intact.
- R6: A store-conditional consumes the reservation for its address whether it passes or fails, so a second store-conditional without a new load-linked fails.
- R7: A store-conditional issued with `bus_lost_i` high fails: it returns 0 with no memory write.
- R8: Up to NUM_RESV distinct addresses are reserved at the same time, and each can then pass a store-conditional.
- R9: With all slots valid, a load-linked to a new address evicts the least recently reserved address. A load-linked to an already reserved address makes that reservation the most recent.
- R10: A snoop matching the store-conditional's address in the same cycle takes priority: the store-conditional fails with no write. A load-linked with a matching snoop in the same cycle leaves the address unreserved.
- R11: An ordinary store asserts `mem_we_o` in the next cycle with no response, and leaves all reservations unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 2 | 01 load-linked, 10 store-conditional, 11 store, 00 idle |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | DATA_W | Store data |
| mem_rdata_i | input | DATA_W | Memory read data for `req_addr_i` |
| snp_valid_i | input | 1 | Remote invalidate or update seen |
| snp_addr_i | input | ADDR_W | Snooped address |
| bus_lost_i | input | 1 | Bus arbitration lost for this store-conditional |
| rsp_valid_o | output | 1 | Response for a load-linked or store-conditional |
| rsp_data_o | output | DATA_W | Loaded value, or 1 / 0 for pass / fail |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory write address |
| mem_wdata_o | output | DATA_W | Memory write data |

## Verification
The hardest state to reach is eviction order with a full table whose recency has been reshuffled. The stimulus fills every slot, refreshes the first reserved address, and then reserves one more address. Only the second-oldest may vanish, and store-conditionals to all five addresses show which one did. Same-cycle collisions between a snoop and a store-conditional or load-linked, and a bus loss on an otherwise valid reservation, are each driven in a single cycle against a reservation set up just before.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_LL   = 2'b01,
    OP_SC   = 2'b10,
    OP_ST   = 2'b11
  } llsc_op_e;
endpackage

// File: rtl/llsc_age_matrix.sv
module llsc_age_matrix #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] oldest_o
);
  // older_q[i][j] set: entry i was touched before entry j
  logic [N-1:0] older_q [N];
  logic [N-1:0] is_oldest;

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      if (i == j) begin : g_diag
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) older_q[i][j] <= 1'b1;
          else         older_q[i][j] <= 1'b1;
      end else begin : g_off
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) older_q[i][j] <= (i < j);
          else if (touch_i && touch_idx_i == IDX_W'(i)) older_q[i][j] <= 1'b0;
          else if (touch_i && touch_idx_i == IDX_W'(j)) older_q[i][j] <= 1'b1;
        end
      end
    end
    assign is_oldest[i] = &older_q[i];
  end

  always_comb begin
    oldest_o = '0;
    for (int k = N - 1; k >= 0; k--)
      if (is_oldest[k]) oldest_o = IDX_W'(k);
  end
endmodule

// File: rtl/llsc_resv_table.sv
module llsc_resv_table #(
  parameter int N      = 4,
  parameter int ADDR_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] q_addr_i,
  output logic              hit_o,
  input  logic              set_i,
  input  logic              consume_i,
  input  logic              snp_i,
  input  logic [ADDR_W-1:0] snp_addr_i
);
  logic [N-1:0]      valid_q;
  logic [ADDR_W-1:0] addr_q [N];
  logic [N-1:0]      q_match, s_match;
  logic [IDX_W-1:0]  hit_idx, free_idx, oldest_idx, set_idx;
  logic              any_free;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign q_match[i] = valid_q[i] && (addr_q[i] == q_addr_i);
    assign s_match[i] = valid_q[i] && (addr_q[i] == snp_addr_i);
  end

  assign hit_o    = |q_match;
  assign any_free = ~&valid_q;

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (q_match[k])  hit_idx  = IDX_W'(k);
      if (!valid_q[k]) free_idx = IDX_W'(k);
    end
  end

  assign set_idx = hit_o ? hit_idx : (any_free ? free_idx : oldest_idx);

  llsc_age_matrix #(.N(N)) u_age (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .touch_i    (set_i),
    .touch_idx_i(set_idx),
    .oldest_o   (oldest_idx)
  );

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[i] <= 1'b0;
        addr_q[i]  <= '0;
      end else if (set_i && set_idx == IDX_W'(i)) begin
        valid_q[i] <= 1'b1;
        addr_q[i]  <= q_addr_i;
      end else if ((snp_i && s_match[i]) || (consume_i && q_match[i])) begin
        valid_q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int NUM_RESV = 4,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              snp_valid_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic              bus_lost_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  import llsc_pkg::*;

  llsc_op_e op;
  logic     is_ll, is_sc, is_st, snp_same, resv_hit, sc_ok;

  assign op       = llsc_op_e'(req_op_i);
  assign is_ll    = req_valid_i && (op == OP_LL);
  assign is_sc    = req_valid_i && (op == OP_SC);
  assign is_st    = req_valid_i && (op == OP_ST);
  assign snp_same = snp_valid_i && (snp_addr_i == req_addr_i);
  assign sc_ok    = is_sc && resv_hit && !snp_same && !bus_lost_i;

  llsc_resv_table #(.N(NUM_RESV), .ADDR_W(ADDR_W)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .q_addr_i  (req_addr_i),
    .hit_o     (resv_hit),
    .set_i     (is_ll && !snp_same),
    .consume_i (is_sc),
    .snp_i     (snp_valid_i),
    .snp_addr_i(snp_addr_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      rsp_valid_o <= is_ll || is_sc;
      mem_we_o    <= is_st || sc_ok;
      if (is_ll)      rsp_data_o <= mem_rdata_i;
      else if (is_sc) rsp_data_o <= DATA_W'(sc_ok);
      if (req_valid_i) begin
        mem_addr_o  <= req_addr_i;
        mem_wdata_o <= req_wdata_i;
      end
    end
  end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [1:0]        req_op_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [DATA_W-1:0] mem_rdata_i,
  input logic              snp_valid_i,
  input logic [ADDR_W-1:0] snp_addr_i,
  input logic              bus_lost_i,
  input logic              rsp_valid_o,
  input logic [DATA_W-1:0] rsp_data_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  assert_write_has_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ($past(req_valid_i) && $past(req_op_i[1])));

  assert_ll_returns_mem_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 2'b01) |=> (rsp_valid_o && rsp_data_o == $past(mem_rdata_i)));

  assert_sc_result_matches_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 2'b10) |=>
      (rsp_valid_o && (mem_we_o == rsp_data_o[0]) && (mem_addr_o == $past(req_addr_i))));

  assert_bus_lost_fails_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 2'b10 && bus_lost_i) |=> (rsp_data_o == '0 && !mem_we_o));

  assert_snoop_beats_sc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 2'b10 && snp_valid_i && snp_addr_i == req_addr_i)
      |=> (rsp_data_o == '0 && !mem_we_o));

  assert_store_no_rsp_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 2'b11) |=> (mem_we_o && !rsp_valid_o));
endmodule

bind llsc_monitor llsc_monitor_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_op_i   (req_op_i),
  .req_addr_i (req_addr_i),
  .mem_rdata_i(mem_rdata_i),
  .snp_valid_i(snp_valid_i),
  .snp_addr_i (snp_addr_i),
  .bus_lost_i (bus_lost_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_data_o (rsp_data_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o)
);

// File: tb/llsc_monitor_bench.sv
module llsc_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] IDLE = 2'b00, LL = 2'b01, SC = 2'b10, ST = 2'b11;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [15:0] mem_rdata;
  logic        snp_valid = 1'b0;
  logic [7:0]  snp_addr = '0;
  logic        bus_lost = 1'b0;
  logic        rsp_valid, mem_we;
  logic [15:0] rsp_data, mem_wdata;
  logic [7:0]  mem_addr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [15:0] mem [256];

  typedef struct {
    int          due;
    logic        rv;
    logic [15:0] data;
    logic        we;
    logic [7:0]  waddr;
    logic [15:0] wdata;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [15:0] init_val(input logic [7:0] a);
    return 16'h1000 + 16'(a) * 16'd7;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(8'(i));
    end else if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
    end
  end
  assign mem_rdata = mem[req_addr];

  always @(posedge clk) cyc <= cyc + 1;

  llsc_monitor u_llsc_monitor (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .mem_rdata_i(mem_rdata),
    .snp_valid_i(snp_valid), .snp_addr_i(snp_addr), .bus_lost_i(bus_lost),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata)
  );

  // monitor: compare outputs of the request driven one cycle earlier
  always @(negedge clk) begin
    if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
      exp_t e;
      logic bad;
      e = exp_q.pop_front();
      checks++;
      bad = (rsp_valid !== e.rv) || (mem_we !== e.we) ||
            (e.rv && rsp_data !== e.data) ||
            (e.we && (mem_addr !== e.waddr || mem_wdata !== e.wdata));
      if (bad) begin
        errors++;
        $display("FAIL %s: rv=%0b data=%h we=%0b addr=%h wdata=%h expected rv=%0b data=%h we=%0b addr=%h wdata=%h",
                 e.tag, rsp_valid, rsp_data, mem_we, mem_addr, mem_wdata,
                 e.rv, e.data, e.we, e.waddr, e.wdata);
      end
    end
  end

  task automatic issue(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d,
                       input logic sv, input logic [7:0] sa, input logic lost,
                       input logic erv, input logic [15:0] ed, input logic ewe,
                       input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = (op != IDLE);
    req_op    = op;
    req_addr  = a;
    req_wdata = d;
    snp_valid = sv;
    snp_addr  = sa;
    bus_lost  = lost;
    e.due = cyc + 1; e.rv = erv; e.data = ed; e.we = ewe;
    e.waddr = a; e.wdata = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input string tag);
    issue(IDLE, 8'h00, 16'h0, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0, 1'b0, tag);
  endtask

  task automatic snoop(input logic [7:0] sa, input string tag);
    issue(IDLE, 8'h00, 16'h0, 1'b1, sa, 1'b0, 1'b0, 16'h0, 1'b0, tag);
  endtask

  task automatic ll(input logic [7:0] a, input logic [15:0] ev, input string tag);
    issue(LL, a, 16'h0, 1'b0, 8'h00, 1'b0, 1'b1, ev, 1'b0, tag);
  endtask

  task automatic sc(input logic [7:0] a, input logic [15:0] d, input logic pass, input string tag);
    issue(SC, a, d, 1'b0, 8'h00, 1'b0, 1'b1, {15'h0, pass}, pass, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || mem_we !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: rv=%0b we=%0b expected 0 0", rsp_valid, mem_we);
    end
    rst_ni = 1'b1;

    sc(8'h05, 16'h1111, 1'b0, "R1 sc after reset");
    idle("R1 idle");
    ll(8'h10, init_val(8'h10), "R2 ll value");
    sc(8'h10, 16'hAAAA, 1'b1, "R3 sc pass");
    idle("R3 idle");
    sc(8'h10, 16'hBBBB, 1'b0, "R6 second sc");
    sc(8'h20, 16'hCCCC, 1'b0, "R4 no reservation");
    ll(8'h10, 16'hAAAA, "R2 ll after write");
    ll(8'h30, init_val(8'h30), "R5 ll");
    snoop(8'h31, "R5 snoop other");
    snoop(8'h10, "R5 snoop match");
    sc(8'h30, 16'h3030, 1'b1, "R5 unmatched survives");
    sc(8'h10, 16'h1010, 1'b0, "R5 matched cleared");

    ll(8'h40, init_val(8'h40), "R7 ll");
    issue(SC, 8'h40, 16'h4040, 1'b0, 8'h00, 1'b1, 1'b1, 16'h0, 1'b0, "R7 bus lost");
    sc(8'h40, 16'h4141, 1'b0, "R6 consumed on fail");

    ll(8'h50, init_val(8'h50), "R10 ll");
    issue(SC, 8'h50, 16'h5050, 1'b1, 8'h50, 1'b0, 1'b1, 16'h0, 1'b0, "R10 snoop same cycle sc");
    issue(LL, 8'h52, 16'h0, 1'b1, 8'h52, 1'b0, 1'b1, init_val(8'h52), 1'b0, "R10 ll with snoop");
    sc(8'h52, 16'h5252, 1'b0, "R10 ll not reserved");

    ll(8'h60, init_val(8'h60), "R11 ll");
    issue(ST, 8'h60, 16'h1234, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0, 1'b1, "R11 store");
    idle("R11 idle");
    sc(8'h60, 16'h5678, 1'b1, "R11 reservation kept");
    idle("R11 idle2");
    ll(8'h60, 16'h5678, "R11 readback");
    sc(8'h60, 16'h0000, 1'b1, "R11 clear slot");

    for (int i = 0; i < 4; i++) ll(8'h70 + 8'(i), init_val(8'h70 + 8'(i)), "R8 ll");
    for (int i = 0; i < 4; i++) sc(8'h70 + 8'(i), 16'h7000 + 16'(i), 1'b1, "R8 sc");

    for (int i = 0; i < 4; i++) ll(8'h80 + 8'(i), init_val(8'h80 + 8'(i)), "R9 fill");
    ll(8'h80, init_val(8'h80), "R9 refresh");
    ll(8'h84, init_val(8'h84), "R9 evict");
    sc(8'h81, 16'h8181, 1'b0, "R9 evicted entry");
    sc(8'h80, 16'h8080, 1'b1, "R9 refreshed kept");
    sc(8'h82, 16'h8282, 1'b1, "R9 kept 82");
    sc(8'h83, 16'h8383, 1'b1, "R9 kept 83");
    sc(8'h84, 16'h8484, 1'b1, "R9 new entry");
    idle("end");

    wait (exp_q.size() == 0);
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule